// File: doc/BRIEF.md
# SPI Control and Status Register Block

This block is the software-facing register layer of an SPI port. It holds a control register with an interrupt enable, an SPI enable and a master enable. It also holds three status flags: transfer complete, write collision and mode fault. It watches the busy, done and slave-select signals of a separate shift engine. It gates writes to the transmit holding register. It raises an interrupt request when a completed transfer meets an enabled interrupt. Software clears the flags by reading the status register.

The operating mode is held in a four-state machine. In `ST_OFF` both enables are clear. In `ST_PARK` master is selected but the port is disabled. In `ST_SLAVE` the port is enabled without master. In `ST_MASTER` both enables are set.

A control write moves the machine to the state that matches the written enable bits: 00 to `ST_OFF`, master-only to `ST_PARK`, SPI-only to `ST_SLAVE`, and both bits to `ST_MASTER`. The transition `MASTER->OFF` (the mode fault) is taken when slave select is driven low while in `ST_MASTER`. That transition overrides any control write in the same cycle. With no event, every state holds. To use the port as a master, software first sets up the baud divisor. It then makes sure the external select is inactive, writes the control register, and only then writes transmit data.

Register map: offset 0 is control, offset 1 is status (read-only), and offset 2 is transmit data. The other offset reads as zero.

Top module: `spi_csr`

## Requirements
- R1: After reset, all control bits, all flags, `irq` and `tx_load` are 0, and every register offset reads 0.
- R2: A write to offset 0 stores bit 7 as interrupt enable, bit 5 as SPI enable and bit 4 as master enable. The outputs follow on the next cycle. A read of offset 0 returns only those three bits, and all other bits read 0.
- R3: A one-cycle `xfer_done` pulse sets the completion flag (status bit 7) on the next cycle.
- R4: `irq` is high exactly when the completion flag and the interrupt enable are both set.
- R5: A write to offset 2 while `xfer_busy` is low loads the data into the transmit register. The new value reads back at offset 2 and appears on `tx_data`, and `tx_load` pulses high for the one cycle after the write.
- R6: A write to offset 2 while `xfer_busy` is high sets the write-collision flag (status bit 5). The data is discarded, `tx_data` and the offset 2 readback keep the old value, and no `tx_load` pulse is produced.
- R7: When `ss_n` is low while both SPI enable and master enable are set, the next cycle has both enables cleared and the mode-fault flag (status bit 4) set. The interrupt enable is unchanged. A low `ss_n` in slave, parked or disabled mode causes no fault.
- R8: After a mode fault the enables stay clear, even when `ss_n` returns high, until software writes the control register again.
- R9: A read of offset 1 returns the current flags in that cycle and clears all of them on the next cycle.
- R10: If a flag's set event arrives in the same cycle as a status read, that flag stays set.
- R11: A mode fault in the same cycle as a control write takes precedence: both enables end up clear. The interrupt enable still takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register offset: 0 control, 1 status, 2 transmit |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_rdata | output | 8 | Read data for the current offset (combinational) |
| xfer_busy | input | 1 | Shift engine has a transfer in progress |
| xfer_done | input | 1 | Shift engine completion pulse |
| ss_n | input | 1 | External slave select, active low |
| ctl_irq_en | output | 1 | Interrupt enable bit |
| ctl_spi_en | output | 1 | SPI enable bit |
| ctl_master_en | output | 1 | Master enable bit |
| flag_done | output | 1 | Transfer complete flag |
| flag_wcol | output | 1 | Write collision flag |
| flag_modf | output | 1 | Mode fault flag |
| irq | output | 1 | Interrupt request |
| tx_data | output | 8 | Transmit holding register contents |
| tx_load | output | 1 | One-cycle pulse marking new transmit data |

## Verification
The timing of each output is fixed:
- Control bits, enables, flags and `tx_load` each pass through one register. They are due in the first cycle after the stimulus edge.
- `irq` is a combination of two such registers, so it is due in the same cycle as they are.
- `reg_rdata` is combinational from the stored state and the offset. It is valid in the cycle of the access itself and shows the flags before a read clears them.

The bench drives all inputs on the falling edge. It compares registered outputs one full period later, on the next falling edge. It samples `reg_rdata` a short delay after the inputs change, still before the rising edge that would clear the flags.

// File: rtl/spi_csr_pkg.sv
package spi_csr_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] OFS_CTL = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_STS = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_TX  = 2'd2;

    localparam int CTL_IRQ_POS = 7;
    localparam int CTL_SPI_POS = 5;
    localparam int CTL_MST_POS = 4;

    localparam int STS_DONE_POS = 7;
    localparam int STS_WCOL_POS = 5;
    localparam int STS_MODF_POS = 4;

    localparam int FLG_DONE = 0;
    localparam int FLG_WCOL = 1;
    localparam int FLG_MODF = 2;
    localparam int NUM_FLAGS = 3;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_PARK   = 2'd1,
        ST_SLAVE  = 2'd2,
        ST_MASTER = 2'd3
    } mode_e;

endpackage

// File: rtl/spi_sticky_flag.sv
module spi_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);

    assert_holds_unprompted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/spi_mode_fsm.sv
module spi_mode_fsm
    import spi_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr_i,
    input  logic wr_spi_i,
    input  logic wr_mst_i,
    input  logic ss_n_i,
    output logic spi_en_o,
    output logic mst_en_o,
    output logic fault_o
);

    mode_e state_q;
    mode_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (state_q == ST_MASTER && !ss_n_i) begin
            state_d = ST_OFF;
        end else if (ctl_wr_i) begin
            unique case ({wr_spi_i, wr_mst_i})
                2'b00: state_d = ST_OFF;
                2'b01: state_d = ST_PARK;
                2'b10: state_d = ST_SLAVE;
                2'b11: state_d = ST_MASTER;
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        spi_en_o = 1'b0;
        mst_en_o = 1'b0;
        fault_o  = 1'b0;
        unique case (state_q)
            ST_OFF: ;
            ST_PARK: mst_en_o = 1'b1;
            ST_SLAVE: spi_en_o = 1'b1;
            ST_MASTER: begin
                spi_en_o = 1'b1;
                mst_en_o = 1'b1;
                fault_o  = !ss_n_i;
            end
            default: ;
        endcase
    end

    assert_fault_drops_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en_o && mst_en_o && !ss_n_i) |=> (!spi_en_o && !mst_en_o));

    assert_off_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !ctl_wr_i) |=> (state_q == ST_OFF));

    assert_fault_beats_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && ctl_wr_i) |=> (state_q == ST_OFF));

endmodule

// File: rtl/spi_csr.sv
module spi_csr
    import spi_csr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              xfer_busy,
    input  logic              xfer_done,
    input  logic              ss_n,
    output logic              ctl_irq_en,
    output logic              ctl_spi_en,
    output logic              ctl_master_en,
    output logic              flag_done,
    output logic              flag_wcol,
    output logic              flag_modf,
    output logic              irq,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_load
);

    logic ctl_wr;
    logic tx_wr;
    logic sts_rd;
    logic collide;
    logic fault;
    logic irq_en_q;
    logic tx_load_q;
    logic [DATA_W-1:0] tx_hold_q;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_q;

    assign ctl_wr  = reg_wr && (reg_addr == OFS_CTL);
    assign tx_wr   = reg_wr && (reg_addr == OFS_TX);
    assign sts_rd  = reg_rd && (reg_addr == OFS_STS);
    assign collide = tx_wr && xfer_busy;

    spi_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr_i (ctl_wr),
        .wr_spi_i (reg_wdata[CTL_SPI_POS]),
        .wr_mst_i (reg_wdata[CTL_MST_POS]),
        .ss_n_i   (ss_n),
        .spi_en_o (ctl_spi_en),
        .mst_en_o (ctl_master_en),
        .fault_o  (fault)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_en_q <= 1'b0;
        else if (ctl_wr)
            irq_en_q <= reg_wdata[CTL_IRQ_POS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_hold_q <= '0;
            tx_load_q <= 1'b0;
        end else begin
            tx_load_q <= tx_wr && !xfer_busy;
            if (tx_wr && !xfer_busy)
                tx_hold_q <= reg_wdata;
        end
    end

    always_comb begin
        flag_set = '0;
        flag_set[FLG_DONE] = xfer_done;
        flag_set[FLG_WCOL] = collide;
        flag_set[FLG_MODF] = fault;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        spi_sticky_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (flag_set[g]),
            .clr_i (sts_rd),
            .q_o   (flag_q[g])
        );
    end

    assign flag_done  = flag_q[FLG_DONE];
    assign flag_wcol  = flag_q[FLG_WCOL];
    assign flag_modf  = flag_q[FLG_MODF];
    assign ctl_irq_en = irq_en_q;
    assign irq        = flag_done && irq_en_q;
    assign tx_data    = tx_hold_q;
    assign tx_load    = tx_load_q;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTL: begin
                reg_rdata[CTL_IRQ_POS] = irq_en_q;
                reg_rdata[CTL_SPI_POS] = ctl_spi_en;
                reg_rdata[CTL_MST_POS] = ctl_master_en;
            end
            OFS_STS: begin
                reg_rdata[STS_DONE_POS] = flag_done;
                reg_rdata[STS_WCOL_POS] = flag_wcol;
                reg_rdata[STS_MODF_POS] = flag_modf;
            end
            OFS_TX: reg_rdata = tx_hold_q;
            default: reg_rdata = '0;
        endcase
    end

    assert_collision_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> (!tx_load && $stable(tx_data)));

    assert_clean_write_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !xfer_busy) |=> tx_load);

    assert_done_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> flag_done);

    assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctl_irq_en && flag_done));

endmodule

// File: tb/tb_spi_csr.sv
module tb_spi_csr;

    logic       clk;
    logic       rst_n;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_wr;
    logic       reg_rd;
    logic [7:0] reg_rdata;
    logic       xfer_busy;
    logic       xfer_done;
    logic       ss_n;
    logic       ctl_irq_en;
    logic       ctl_spi_en;
    logic       ctl_master_en;
    logic       flag_done;
    logic       flag_wcol;
    logic       flag_modf;
    logic       irq;
    logic [7:0] tx_data;
    logic       tx_load;

    int total;
    int bad;
    bit finished;

    spi_csr dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_rdata     (reg_rdata),
        .xfer_busy     (xfer_busy),
        .xfer_done     (xfer_done),
        .ss_n          (ss_n),
        .ctl_irq_en    (ctl_irq_en),
        .ctl_spi_en    (ctl_spi_en),
        .ctl_master_en (ctl_master_en),
        .flag_done     (flag_done),
        .flag_wcol     (flag_wcol),
        .flag_modf     (flag_modf),
        .irq           (irq),
        .tx_data       (tx_data),
        .tx_load       (tx_load)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // {wr, rd, addr, wdata, busy, done, ss_n, expected}
    // expected = {irq_en, spi_en, master_en, done, wcol, modf, irq, tx_load}
    localparam int NV = 20;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1,1'b0,2'd0,8'hB0,1'b0,1'b0,1'b1,8'hE0}, // R2 enter master
        {1'b0,1'b0,2'd0,8'h00,1'b0,1'b1,1'b1,8'hF2}, // R3 R4 done pulse
        {1'b0,1'b1,2'd1,8'h00,1'b0,1'b0,1'b1,8'hE0}, // R9 read clears
        {1'b1,1'b0,2'd2,8'h5A,1'b0,1'b0,1'b1,8'hE1}, // R5 clean tx write
        {1'b1,1'b0,2'd2,8'h33,1'b1,1'b0,1'b1,8'hE8}, // R6 collision
        {1'b0,1'b1,2'd1,8'h00,1'b0,1'b1,1'b1,8'hF2}, // R10 done wins over read
        {1'b0,1'b1,2'd1,8'h00,1'b0,1'b0,1'b1,8'hE0}, // R9
        {1'b0,1'b0,2'd0,8'h00,1'b0,1'b0,1'b0,8'h84}, // R7 mode fault
        {1'b0,1'b0,2'd0,8'h00,1'b0,1'b0,1'b1,8'h84}, // R8 stays cleared
        {1'b0,1'b1,2'd1,8'h00,1'b0,1'b0,1'b1,8'h80}, // R9 modf cleared
        {1'b1,1'b0,2'd0,8'h20,1'b0,1'b0,1'b1,8'h40}, // R2 slave
        {1'b0,1'b0,2'd0,8'h00,1'b0,1'b0,1'b0,8'h40}, // R7 no fault in slave
        {1'b1,1'b0,2'd0,8'h10,1'b0,1'b0,1'b0,8'h20}, // R2 parked master
        {1'b0,1'b0,2'd0,8'h00,1'b0,1'b0,1'b0,8'h20}, // R7 no fault when parked
        {1'b1,1'b0,2'd0,8'h30,1'b0,1'b0,1'b1,8'h60}, // R2 master, irq off
        {1'b1,1'b0,2'd0,8'hB0,1'b0,1'b0,1'b0,8'h84}, // R11 fault beats write
        {1'b0,1'b0,2'd0,8'h00,1'b0,1'b1,1'b1,8'h96}, // R4 irq with modf
        {1'b0,1'b1,2'd1,8'h00,1'b0,1'b0,1'b1,8'h80}, // R9 clears both
        {1'b1,1'b0,2'd0,8'h00,1'b0,1'b0,1'b1,8'h00}, // R2 all off
        {1'b0,1'b0,2'd0,8'h00,1'b0,1'b1,1'b1,8'h10}  // R4 no irq when disabled
    };
    localparam int VREQ [NV] = '{2,3,9,5,6,10,9,7,8,9,2,7,2,7,2,11,4,9,2,4};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic rd, input logic [1:0] addr,
                         input logic [7:0] wd, input logic busy, input logic done,
                         input logic ssn);
        reg_wr = wr; reg_rd = rd; reg_addr = addr; reg_wdata = wd;
        xfer_busy = busy; xfer_done = done; ss_n = ssn;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1);
    endtask

    function automatic logic [7:0] obs();
        return {ctl_irq_en, ctl_spi_en, ctl_master_en, flag_done,
                flag_wcol, flag_modf, irq, tx_load};
    endfunction

    task automatic peek(input string req, input logic [1:0] addr, input logic [7:0] exp);
        reg_addr = addr;
        #2;
        check(req, reg_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        total = 0;
        bad = 0;
        finished = 0;
        rst_n = 1'b0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 outputs", obs(), 8'h00);
        peek("R1 ctl read", 2'd0, 8'h00);
        peek("R1 sts read", 2'd1, 8'h00);
        peek("R1 tx read", 2'd2, 8'h00);
        check("R1 tx_data", tx_data, 8'h00);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][22], VEC[i][21], VEC[i][20:19], VEC[i][18:11],
                  VEC[i][10], VEC[i][9], VEC[i][8]);
            @(negedge clk);
            idle();
            check($sformatf("R%0d table row %0d", VREQ[i], i), obs(), VEC[i][7:0]);
        end

        // R2 unused control bits read as zero
        drive(1'b1, 1'b0, 2'd0, 8'hFF, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        idle();
        peek("R2 ctl mask", 2'd0, 8'hB0);
        @(negedge clk);

        // R9 read returns flags in the read cycle, then clears them
        drive(1'b0, 1'b1, 2'd1, 8'h00, 1'b0, 1'b0, 1'b1);
        #2;
        check("R9 read value", reg_rdata, 8'h80);
        @(negedge clk);
        idle();
        check("R9 cleared", {7'd0, flag_done}, 8'h00);

        // R5 clean write loads data
        drive(1'b1, 1'b0, 2'd2, 8'hA5, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        idle();
        check("R5 tx_data", tx_data, 8'hA5);
        peek("R5 tx read", 2'd2, 8'hA5);
        @(negedge clk);
        check("R5 single pulse", {7'd0, tx_load}, 8'h00);

        // R6 colliding write discarded
        drive(1'b1, 1'b0, 2'd2, 8'h3C, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        idle();
        check("R6 no load", {7'd0, tx_load}, 8'h00);
        check("R6 tx_data kept", tx_data, 8'hA5);
        peek("R6 tx read kept", 2'd2, 8'hA5);
        peek("R6 sts wcol", 2'd1, 8'h20);
        @(negedge clk);

        // R8 fault survives idle cycles until rewrite
        drive(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        idle();
        repeat (3) @(negedge clk);
        peek("R8 ctl after fault", 2'd0, 8'h80);
        peek("R7 sts modf", 2'd1, 8'h30);
        drive(1'b1, 1'b0, 2'd0, 8'h30, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        idle();
        check("R8 rewrite restores", {6'd0, ctl_spi_en, ctl_master_en}, 8'h03);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule